// File: doc/BRIEF.md
# Filtered GPIO Bank with Wake

This block is a parameterized bank of general-purpose pins with a simple register port made of address, write data, write enable and read data. Each pin is programmed as an input or an output. An input pin first crosses a synchronizer, then a per-pin debounce counter that accepts a new level only once it has held steady for a set number of clocks. Edge detection on that cleaned level sets sticky status bits. These status bits feed an interrupt line and a wake request line through separate per-pin enables.

The output side keeps a driven-value register. Software can overwrite it whole, or change single bits through a set port and a clear port without a read-modify-write. While the standby input is high, each pin drives a preloaded standby value in place of its normal value. Edge capture keeps running during standby, so an input can still raise the wake request.

Top module: `gpio_wake_bank`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all 0), the driven value, status, `irq` and `wake` are all 0, and every mode register reads 0.
- R2: Bit i of the direction register (address 0, 1 = output) drives `pin_oe[i]`. Every bit is programmed independently.
- R3: With bypass off, a change on a synchronized input is taken up only after it has been present for FILT_LEN (default 5) consecutive clock samples. A pulse of fewer samples is dropped and sets no status bit.
- R4: Bit i of the bypass register (address 11, reset 0) routes the synchronized level of pin i around the debounce counter, so a one-cycle pulse is seen.
- R5: Bit i of the rising-edge enable register (address 7) and of the falling-edge enable register (address 8) select which transitions of the cleaned level of pin i set status. Setting both selects both transitions.
- R6: Status (address 9) is sticky. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and a new edge in the same cycle wins over the clear.
- R7: `irq` is high exactly when some status bit is set whose interrupt enable (address 5) is also set.
- R8: `wake` is high exactly when some status bit is set whose wake enable (address 6) is also set. Edges are still captured while `stby` is high.
- R9: A pin programmed as an output never sets its status bit, whatever its input does.
- R10: Address 1 writes the driven value whole. A 1 written to address 2 sets that bit and a 1 written to address 3 clears that bit. A 0 leaves the bit unchanged, and addresses 2 and 3 read as 0.
- R11: While `stby` is high, `pin_out` equals the standby value register (address 10). When `stby` falls, the normal driven value returns.
- R12: A read of address 4 returns, per pin, the cleaned input level for inputs and the value on `pin_out` for outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | NPINS | Write data |
| rdata | output | NPINS | Read data for `addr` (combinational) |
| pin_in | input | NPINS | Raw pin input levels |
| stby | input | 1 | Standby request |
| pin_out | output | NPINS | Value driven on output pins |
| pin_oe | output | NPINS | Per-pin output enable |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request |

## Verification
The bench builds the bank with its defaults: eight pins, a five-sample debounce window and a two-stage synchronizer. The upper four pins are outputs and the lower four are inputs, so a single run exercises the set and clear ports, the standby override, and the mixed read of address 4. A five-sample window keeps the accept threshold close to the edge of the random pulse lengths of one to eight cycles. This makes the four-versus-five boundary a frequent event rather than a rare one.

// File: rtl/gpio_wake_pkg.sv
package gpio_wake_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIR    = 4'd0,
        REG_OUT    = 4'd1,
        REG_SET    = 4'd2,
        REG_CLR    = 4'd3,
        REG_IN     = 4'd4,
        REG_IRQEN  = 4'd5,
        REG_WAKEEN = 4'd6,
        REG_RISE   = 4'd7,
        REG_FALL   = 4'd8,
        REG_STAT   = 4'd9,
        REG_STBY   = 4'd10,
        REG_BYP    = 4'd11
    } reg_addr_e;

    // Per-pin configuration slice handed to each input lane
    typedef struct packed {
        logic is_out;
        logic bypass;
        logic rise_en;
        logic fall_en;
    } lane_cfg_t;

    function automatic logic edge_match(input logic prev, input logic cur,
                                        input logic rise_en, input logic fall_en);
        return (rise_en & ~prev & cur) | (fall_en & prev & ~cur);
    endfunction

endpackage

// File: rtl/gpio_sync_filter.sv
module gpio_sync_filter #(
    parameter int FILT_LEN    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic bypass,
    output logic sync_o,
    output logic filt_o,
    output logic level_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_sr;
    logic [CNT_W-1:0]       cnt_q;
    logic                   filt_q;

    always_ff @(posedge clk) begin
        if (rst) sync_sr <= '0;
        else     sync_sr <= {sync_sr[SYNC_STAGES-2:0], raw};
    end

    assign sync_o = sync_sr[SYNC_STAGES-1];

    // Counts samples that disagree with the accepted level
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            filt_q <= 1'b0;
        end else if (sync_o == filt_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
            filt_q <= sync_o;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign filt_o  = filt_q;
    assign level_o = bypass ? sync_o : filt_q;

endmodule

// File: rtl/gpio_edge_lane.sv
module gpio_edge_lane
    import gpio_wake_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lane_cfg_t cfg,
    input  logic      level,
    output logic      edge_hit
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    assign edge_hit = ~cfg.is_out & edge_match(prev_q, level, cfg.rise_en, cfg.fall_en);

endmodule

// File: rtl/gpio_csr.sv
module gpio_csr
    import gpio_wake_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    output logic [NPINS-1:0]  rdata,
    input  logic [NPINS-1:0]  edge_hit,
    input  logic [NPINS-1:0]  in_level,
    input  logic [NPINS-1:0]  pin_drv,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  out_q,
    output logic [NPINS-1:0]  stby_val_q,
    output logic [NPINS-1:0]  bypass_q,
    output logic [NPINS-1:0]  rise_q,
    output logic [NPINS-1:0]  fall_q,
    output logic [NPINS-1:0]  irq_en_q,
    output logic [NPINS-1:0]  wake_en_q,
    output logic [NPINS-1:0]  status_q
);
    reg_addr_e        sel;
    logic [NPINS-1:0] w1c_mask;

    assign sel      = reg_addr_e'(addr);
    assign w1c_mask = (we && sel == REG_STAT) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q      <= '0;
            out_q      <= '0;
            stby_val_q <= '0;
            bypass_q   <= '0;
            rise_q     <= '0;
            fall_q     <= '0;
            irq_en_q   <= '0;
            wake_en_q  <= '0;
        end else if (we) begin
            case (sel)
                REG_DIR:    dir_q      <= wdata;
                REG_OUT:    out_q      <= wdata;
                REG_SET:    out_q      <= out_q | wdata;
                REG_CLR:    out_q      <= out_q & ~wdata;
                REG_IRQEN:  irq_en_q   <= wdata;
                REG_WAKEEN: wake_en_q  <= wdata;
                REG_RISE:   rise_q     <= wdata;
                REG_FALL:   fall_q     <= wdata;
                REG_STBY:   stby_val_q <= wdata;
                REG_BYP:    bypass_q   <= wdata;
                default: ;
            endcase
        end
    end

    // New edges take priority over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~w1c_mask) | edge_hit;
    end

    always_comb begin
        case (sel)
            REG_DIR:    rdata = dir_q;
            REG_OUT:    rdata = out_q;
            REG_IN:     rdata = (pin_drv & dir_q) | (in_level & ~dir_q);
            REG_IRQEN:  rdata = irq_en_q;
            REG_WAKEEN: rdata = wake_en_q;
            REG_RISE:   rdata = rise_q;
            REG_FALL:   rdata = fall_q;
            REG_STAT:   rdata = status_q;
            REG_STBY:   rdata = stby_val_q;
            REG_BYP:    rdata = bypass_q;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_wake_bank.sv
module gpio_wake_bank
    import gpio_wake_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int FILT_LEN    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    output logic [NPINS-1:0]  rdata,
    input  logic [NPINS-1:0]  pin_in,
    input  logic              stby,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq,
    output logic              wake
);
    logic [NPINS-1:0] dir_q, out_q, stby_val_q, bypass_q;
    logic [NPINS-1:0] rise_q, fall_q, irq_en_q, wake_en_q, status_q;
    logic [NPINS-1:0] sync_lvl, filt_lvl, in_level, edge_hit;

    for (genvar i = 0; i < NPINS; i++) begin : g_lane
        lane_cfg_t cfg;
        assign cfg = '{is_out: dir_q[i], bypass: bypass_q[i],
                       rise_en: rise_q[i], fall_en: fall_q[i]};

        gpio_sync_filter #(
            .FILT_LEN    (FILT_LEN),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_filt (
            .clk     (clk),
            .rst     (rst),
            .raw     (pin_in[i]),
            .bypass  (cfg.bypass),
            .sync_o  (sync_lvl[i]),
            .filt_o  (filt_lvl[i]),
            .level_o (in_level[i])
        );

        gpio_edge_lane u_edge (
            .clk      (clk),
            .rst      (rst),
            .cfg      (cfg),
            .level    (in_level[i]),
            .edge_hit (edge_hit[i])
        );
    end

    gpio_csr #(.NPINS(NPINS)) u_csr (
        .clk        (clk),
        .rst        (rst),
        .we         (we),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .edge_hit   (edge_hit),
        .in_level   (in_level),
        .pin_drv    (pin_out),
        .dir_q      (dir_q),
        .out_q      (out_q),
        .stby_val_q (stby_val_q),
        .bypass_q   (bypass_q),
        .rise_q     (rise_q),
        .fall_q     (fall_q),
        .irq_en_q   (irq_en_q),
        .wake_en_q  (wake_en_q),
        .status_q   (status_q)
    );

    assign pin_out = stby ? stby_val_q : out_q;
    assign pin_oe  = dir_q;
    assign irq     = |(status_q & irq_en_q);
    assign wake    = |(status_q & wake_en_q);

endmodule

// File: rtl/gpio_wake_bank_chk.sv
module gpio_wake_bank_chk
    import gpio_wake_pkg::*;
#(
    parameter int NPINS    = 8,
    parameter int FILT_LEN = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [NPINS-1:0]  wdata,
    input logic              stby,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic              irq,
    input logic              wake,
    input logic [NPINS-1:0]  status,
    input logic [NPINS-1:0]  sync_lvl,
    input logic [NPINS-1:0]  filt_lvl
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [NPINS-1:0] sync_d;
    logic [CW-1:0]    run_len [NPINS];

    // Length of the current run of equal synchronized samples, saturating
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_d <= '0;
            for (int i = 0; i < NPINS; i++) run_len[i] <= '0;
        end else begin
            sync_d <= sync_lvl;
            for (int i = 0; i < NPINS; i++) begin
                if (sync_lvl[i] != sync_d[i])           run_len[i] <= CW'(1);
                else if (run_len[i] < CW'(FILT_LEN))    run_len[i] <= run_len[i] + 1'b1;
            end
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && status == '0));

    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status != '0));

    // R8
    wake_source_chk: assert property (@(posedge clk) disable iff (rst)
        wake |-> (status != '0));

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(stby) && !$past(we)) |-> $stable(pin_out));

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        // R3
        filt_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (filt_lvl[i] != $past(filt_lvl[i])) |-> (run_len[i] >= CW'(FILT_LEN)));

        // R6
        sticky_chk: assert property (@(posedge clk) disable iff (rst)
            ($past(status[i]) && !($past(we) && $past(addr) == REG_STAT && $past(wdata[i])))
            |-> status[i]);

        // R9
        out_no_status_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(status[i]) && status[i]) |-> !$past(pin_oe[i]));
    end

endmodule

bind gpio_wake_bank gpio_wake_bank_chk #(
    .NPINS    (NPINS),
    .FILT_LEN (FILT_LEN)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .we       (we),
    .addr     (addr),
    .wdata    (wdata),
    .stby     (stby),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .irq      (irq),
    .wake     (wake),
    .status   (status_q),
    .sync_lvl (sync_lvl),
    .filt_lvl (filt_lvl)
);

// File: tb/gpio_wake_bank_bench.sv
module gpio_wake_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP         = 8;
    localparam int FL         = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          we  = 1'b0;
    logic [3:0]    addr = '0;
    logic [NP-1:0] wdata = '0;
    logic [NP-1:0] rdata;
    logic [NP-1:0] pin_in = '0;
    logic          stby = 1'b0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq, wake;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_wake_bank #(.NPINS(NP), .FILT_LEN(FL)) u_gpio_wake_bank (
        .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
        .pin_in(pin_in), .stby(stby), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq(irq), .wake(wake)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [NP-1:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [NP-1:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int p, input int len);
        @(negedge clk);
        pin_in[p] = 1'b1;
        repeat (len) @(negedge clk);
        pin_in[p] = 1'b0;
        idle(20);
    endtask

    function automatic bit accepted(input int len);
        return len >= FL;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] d;
        void'($urandom(32'd2718));
        idle(4);
        rst = 1'b0;
        idle(2);

        // R1 reset state
        check("R1 oe", pin_oe, 0);
        check("R1 out", pin_out, 0);
        check("R1 irq/wake", {irq, wake}, 0);
        rd(4'd0, d);  check("R1 dir", d, 0);
        rd(4'd9, d);  check("R1 stat", d, 0);
        rd(4'd11, d); check("R1 bypass", d, 0);

        // R2 direction
        wr(4'd0, 8'hF0);
        #1 check("R2 oe", pin_oe, 8'hF0);

        // R10 whole write, set, clear
        wr(4'd1, 8'h30);
        wr(4'd2, 8'h80); #1 check("R10 set", pin_out, 8'hB0);
        wr(4'd3, 8'h10); #1 check("R10 clr", pin_out, 8'hA0);
        wr(4'd2, 8'h00); wr(4'd3, 8'h00);
        rd(4'd1, d); check("R10 zero writes", d, 8'hA0);
        rd(4'd2, d); check("R10 set reads 0", d, 0);

        // R12 mixed input read
        pin_in = 8'hF5; idle(15);
        rd(4'd4, d); check("R12 in read", d, 8'hA5);
        pin_in = 8'hF0; idle(15);
        wr(4'd9, 8'hFF);

        // R3 boundary: FL-1 samples dropped, FL samples accepted
        wr(4'd7, 8'h01); wr(4'd8, 8'h00);
        pulse(0, FL - 1);
        rd(4'd9, d); check("R3 short dropped", d, 0);
        pulse(0, FL);
        rd(4'd9, d); check("R3 exact accepted", d, 8'h01);
        wr(4'd9, 8'hFF);

        // R3 R5 R7 random pulses
        for (int it = 0; it < 40; it++) begin
            int p, len;
            logic [NP-1:0] re, fe, ie, exp_st;
            p   = $urandom % 4;
            len = 1 + $urandom % 8;
            re  = NP'($urandom); fe = NP'($urandom); ie = NP'($urandom);
            wr(4'd7, re); wr(4'd8, fe); wr(4'd5, ie);
            wr(4'd9, 8'hFF);
            pulse(p, len);
            exp_st = '0;
            if (accepted(len) && (re[p] || fe[p])) exp_st[p] = 1'b1;
            rd(4'd9, d); check("R3 R5 random status", d, exp_st);
            check("R7 random irq", irq, |(exp_st & ie));
        end
        wr(4'd5, 8'h00);
        wr(4'd9, 8'hFF);

        // R5 falling only
        wr(4'd7, 8'h00); wr(4'd8, 8'h01);
        @(negedge clk) pin_in[0] = 1'b1; idle(15);
        rd(4'd9, d); check("R5 rise ignored", d, 0);
        @(negedge clk) pin_in[0] = 1'b0; idle(15);
        rd(4'd9, d); check("R5 fall seen", d, 8'h01);

        // R6 write-one-to-clear
        wr(4'd9, 8'h00); rd(4'd9, d); check("R6 zero write", d, 8'h01);
        wr(4'd9, 8'hFE); rd(4'd9, d); check("R6 other bits", d, 8'h01);
        wr(4'd9, 8'h01); rd(4'd9, d); check("R6 cleared", d, 0);

        // R4 bypass passes a one-cycle pulse
        wr(4'd11, 8'h01); wr(4'd7, 8'h01); wr(4'd8, 8'h00);
        pulse(0, 1);
        rd(4'd9, d); check("R4 bypass pulse", d, 8'h01);
        wr(4'd11, 8'h00); idle(10); wr(4'd9, 8'hFF);

        // R9 output pin sets no status
        wr(4'd7, 8'h10); wr(4'd8, 8'h10);
        @(negedge clk) pin_in[4] = 1'b0; idle(15);
        @(negedge clk) pin_in[4] = 1'b1; idle(15);
        rd(4'd9, d); check("R9 output no status", d, 0);

        // R11 R8 standby
        wr(4'd10, 8'h0F);
        @(negedge clk) stby = 1'b1;
        #1 check("R11 standby value", pin_out, 8'h0F);
        rd(4'd4, d); check("R12 in read in standby", d, 8'h00);
        wr(4'd6, 8'h02); wr(4'd5, 8'h00); wr(4'd7, 8'h02); wr(4'd8, 8'h00);
        wr(4'd9, 8'hFF);
        pulse(1, 8);
        check("R8 wake in standby", wake, 1);
        check("R7 irq masked", irq, 0);
        @(negedge clk) stby = 1'b0;
        #1 check("R11 restored", pin_out, 8'hA0);
        check("R8 wake sticky", wake, 1);
        wr(4'd9, 8'h02);
        #1 check("R8 wake cleared", wake, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule